// File: doc/BRIEF.md
# Peripheral Clock and Reset Control Bank

This block is a small memory-mapped register bank. It holds one reset line and one clock-stop bit for each of 64 peripherals. Each group of 64 bits is spread over two 32-bit registers. Software never writes a register outright. Every register has two addresses: a write to the base address sets the bits that carry a one, and a write to the base plus four clears them. Bits written as zero keep their value at both addresses. Because of this, two agents can each flip their own bits without doing a read-modify-write.

The stored reset bits drive the per-peripheral reset outputs directly; a one holds that peripheral in reset. The stored clock-stop bits go through a per-bit polarity mask, so every clock-enable output is active-high. A stored one normally stops the clock. Line 14 is wired the other way round: a stored one on that line enables its clock. Reads return the register contents in the same cycle. Both output vectors come from flops and change at the clock edge that takes the write.

Top module: `clkrst_ctrl_bank`

## Requirements
- R1: After synchronous reset, `rst_o` is all ones and `clk_en_o` is all zeros. The reset registers read 0xFFFFFFFF. The clock-stop register at 0x080 reads 0xFFFFBFFF and the one at 0x090 reads 0xFFFFFFFF.
- R2: A write to a base address (0x040 or 0x050 for reset, 0x080 or 0x090 for clock-stop) sets every bit of that register that is written as one. Bits written as zero keep their value.
- R3: A write to a base address plus 4 clears every bit of that register that is written as one. Bits written as zero keep their value.
- R4: Line i (0 to 63) lives in bit i mod 32 of the first register of its pair (0x040 or 0x080) when i < 32, and of the second register (0x050 or 0x090) otherwise. It drives `rst_o[i]` and `clk_en_o[i]`.
- R5: `rst_o[i]` equals the stored reset bit of line i, and 1 means the peripheral is held in reset.
- R6: For every line except 14, `clk_en_o[i]` is the inverse of its stored clock-stop bit. For line 14, `clk_en_o[14]` equals the stored bit.
- R7: A read with `bus_sel`=1 and `bus_we`=0 at a base address or at its +4 alias returns the current value of that register on `bus_rdata` in the same cycle.
- R8: `rst_o` and `clk_en_o` keep their old value while a write is presented. They take the new value from the rising clock edge that accepts the write.
- R9: A write to an address outside the eight mapped addresses, or with `bus_sel`=0, changes no register and no output. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data, used as the set or clear mask |
| bus_rdata | output | 32 | Read data, combinational |
| rst_o | output | 64 | Per-peripheral reset, 1 = held in reset |
| clk_en_o | output | 64 | Per-peripheral clock enable, active-high |

## Verification
The bench looks for these corner cases:
- Mixed one/zero masks at both aliases. A design that wrote the data plainly instead of merging it would wipe out the bits written as zero.
- Lines 32 and 63 in the upper register. A wrong mod-32 mapping or register select would move those changes to other outputs.
- Line 14, in both directions. A uniform polarity would leave that clock enabled after reset, or enable it on the wrong stored value.
- Unmapped addresses near the mapped ones, and writes with the strobe low. A loose decoder would let these corrupt state.
- The exact edge where the outputs change. An extra pipeline stage would show up a cycle late.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;

    localparam int REG_W      = 32;
    localparam int LINES      = 64;
    localparam int ADDR_W     = 12;
    localparam int RST_BASE   = 'h040;
    localparam int STOP_BASE  = 'h080;
    localparam int REG_STRIDE = 'h10;
    localparam int CLR_OFS    = 4;

    // Which alias of a register an access targets
    typedef enum logic {
        ALIAS_SET = 1'b0,
        ALIAS_CLR = 1'b1
    } alias_e;

    // Decode result for one register
    typedef struct packed {
        logic   hit;
        alias_e kind;
    } acc_t;

    function automatic int alias_addr(input int base, input int k, input alias_e kind);
        return base + k * REG_STRIDE + ((kind == ALIAS_CLR) ? CLR_OFS : 0);
    endfunction

endpackage

// File: rtl/clkrst_addr_dec.sv
module clkrst_addr_dec
    import clkrst_pkg::*;
#(
    parameter int ADDR_W_P    = clkrst_pkg::ADDR_W,
    parameter int N_REGS      = 2,
    parameter int RST_BASE_P  = clkrst_pkg::RST_BASE,
    parameter int STOP_BASE_P = clkrst_pkg::STOP_BASE
) (
    input  logic                 sel,
    input  logic [ADDR_W_P-1:0]  addr,
    output acc_t [N_REGS-1:0]    rst_acc,
    output acc_t [N_REGS-1:0]    stop_acc
);

    always_comb begin
        for (int k = 0; k < N_REGS; k++) begin
            rst_acc[k]  = '{hit: 1'b0, kind: ALIAS_SET};
            stop_acc[k] = '{hit: 1'b0, kind: ALIAS_SET};
            if (sel) begin
                if (addr == ADDR_W_P'(alias_addr(RST_BASE_P, k, ALIAS_SET)))
                    rst_acc[k] = '{hit: 1'b1, kind: ALIAS_SET};
                else if (addr == ADDR_W_P'(alias_addr(RST_BASE_P, k, ALIAS_CLR)))
                    rst_acc[k] = '{hit: 1'b1, kind: ALIAS_CLR};
                if (addr == ADDR_W_P'(alias_addr(STOP_BASE_P, k, ALIAS_SET)))
                    stop_acc[k] = '{hit: 1'b1, kind: ALIAS_SET};
                else if (addr == ADDR_W_P'(alias_addr(STOP_BASE_P, k, ALIAS_CLR)))
                    stop_acc[k] = '{hit: 1'b1, kind: ALIAS_CLR};
            end
        end
    end

endmodule

// File: rtl/clkrst_sc_reg.sv
module clkrst_sc_reg #(
    parameter int          W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q,
    output logic [W-1:0] q_next
);

    logic [W-1:0] set_bits, clr_bits;

    // Clear takes priority if both strobes arrive together
    always_comb begin
        set_bits = set_stb ? mask : '0;
        clr_bits = clr_stb ? mask : '0;
        q_next   = (q | set_bits) & ~clr_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= q_next;
    end

    AST_SET_MERGE: assert property (@(posedge clk) disable iff (rst)
        (set_stb && !clr_stb) |=> (((q & $past(mask)) == $past(mask)) &&
                                   ((q & ~$past(mask)) == ($past(q) & ~$past(mask))))); // R2
    AST_CLR_MERGE: assert property (@(posedge clk) disable iff (rst)
        clr_stb |=> (((q & $past(mask)) == '0) &&
                     ((q & ~$past(mask)) == ($past(q) & ~$past(mask))))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!set_stb && !clr_stb) |=> $stable(q)); // R9

endmodule

// File: rtl/clkrst_ctrl_bank.sv
module clkrst_ctrl_bank
    import clkrst_pkg::*;
#(
    parameter int               REG_W_P     = clkrst_pkg::REG_W,
    parameter int               LINES_P     = clkrst_pkg::LINES,
    parameter int               ADDR_W_P    = clkrst_pkg::ADDR_W,
    parameter int               RST_BASE_P  = clkrst_pkg::RST_BASE,
    parameter int               STOP_BASE_P = clkrst_pkg::STOP_BASE,
    parameter logic [63:0]      INV_MASK    = 64'h0000_0000_0000_4000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W_P-1:0]  bus_addr,
    input  logic [REG_W_P-1:0]   bus_wdata,
    output logic [REG_W_P-1:0]   bus_rdata,
    output logic [LINES_P-1:0]   rst_o,
    output logic [LINES_P-1:0]   clk_en_o
);

    localparam int                 N_REGS   = LINES_P / REG_W_P;
    localparam logic [LINES_P-1:0] POL      = INV_MASK[LINES_P-1:0];
    localparam logic [LINES_P-1:0] STOP_RST = ~POL;
    localparam logic [LINES_P-1:0] EN_RST   = ~STOP_RST ^ POL;

    acc_t [N_REGS-1:0] rst_acc, stop_acc;

    logic [N_REGS-1:0][REG_W_P-1:0] rst_q, rst_d, stop_q, stop_d;
    logic [LINES_P-1:0]             clk_en_q;

    clkrst_addr_dec #(
        .ADDR_W_P    (ADDR_W_P),
        .N_REGS      (N_REGS),
        .RST_BASE_P  (RST_BASE_P),
        .STOP_BASE_P (STOP_BASE_P)
    ) u_dec (
        .sel      (bus_sel),
        .addr     (bus_addr),
        .rst_acc  (rst_acc),
        .stop_acc (stop_acc)
    );

    for (genvar k = 0; k < N_REGS; k++) begin : g_reg
        clkrst_sc_reg #(
            .W       (REG_W_P),
            .RST_VAL ({REG_W_P{1'b1}})
        ) u_rst (
            .clk     (clk),
            .rst     (rst),
            .set_stb (bus_we && rst_acc[k].hit && rst_acc[k].kind == ALIAS_SET),
            .clr_stb (bus_we && rst_acc[k].hit && rst_acc[k].kind == ALIAS_CLR),
            .mask    (bus_wdata),
            .q       (rst_q[k]),
            .q_next  (rst_d[k])
        );

        clkrst_sc_reg #(
            .W       (REG_W_P),
            .RST_VAL (STOP_RST[k*REG_W_P +: REG_W_P])
        ) u_stop (
            .clk     (clk),
            .rst     (rst),
            .set_stb (bus_we && stop_acc[k].hit && stop_acc[k].kind == ALIAS_SET),
            .clr_stb (bus_we && stop_acc[k].hit && stop_acc[k].kind == ALIAS_CLR),
            .mask    (bus_wdata),
            .q       (stop_q[k]),
            .q_next  (stop_d[k])
        );
    end

    // Enable flops load the polarity-corrected next state
    always_ff @(posedge clk) begin
        if (rst) clk_en_q <= EN_RST;
        else     clk_en_q <= ~stop_d ^ POL;
    end

    assign rst_o    = rst_q;
    assign clk_en_o = clk_en_q;

    logic any_hit;
    always_comb begin
        bus_rdata = '0;
        any_hit   = 1'b0;
        for (int k = 0; k < N_REGS; k++) begin
            if (rst_acc[k].hit)  bus_rdata = rst_q[k];
            if (stop_acc[k].hit) bus_rdata = stop_q[k];
            any_hit = any_hit | rst_acc[k].hit | stop_acc[k].hit;
        end
    end

    AST_CLKEN_POLARITY: assert property (@(posedge clk) disable iff (rst)
        clk_en_q == (~stop_q ^ POL)); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !any_hit) |-> bus_rdata == '0); // R9
    AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_we) |=> ($stable(rst_o) && $stable(clk_en_o))); // R8

endmodule

// File: tb/tb_clkrst_ctrl_bank.sv
module tb_clkrst_ctrl_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] rst_o, clk_en_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] m_rst, m_stop;

    always #4 clk = ~clk;

    clkrst_ctrl_bank dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_o(rst_o), .clk_en_o(clk_en_o)
    );

    function automatic logic [63:0] exp_en(input logic [63:0] stop);
        logic [63:0] e;
        for (int i = 0; i < 64; i++) e[i] = (i == 14) ? stop[i] : ~stop[i];
        return e;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic s);
        @(negedge clk);
        bus_sel = s; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic chk_outputs(input string req);
        chk({req, " rst_o"}, rst_o, m_rst);
        chk({req, " clk_en_o"}, clk_en_o, exp_en(m_stop));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 rst_o", rst_o, '1);
        chk("R1 clk_en_o", clk_en_o, '0);
        rd(12'h040, d); chk("R1 rd 040", 64'(d), 64'hFFFF_FFFF);
        rd(12'h090, d); chk("R1 rd 090", 64'(d), 64'hFFFF_FFFF);
        rd(12'h080, d); chk("R1 rd 080", 64'(d), 64'hFFFF_BFFF);
    endtask

    task automatic t_set_clear_reset;
        logic [31:0] d;
        wr(12'h044, 32'h0000_F0F0, 1'b1); m_rst[31:0] &= ~32'h0000_F0F0;
        chk_outputs("R3");
        rd(12'h040, d); chk("R3 rd 040", 64'(d), 64'hFFFF_0F0F);
        wr(12'h040, 32'h0000_1010, 1'b1); m_rst[31:0] |= 32'h0000_1010;
        chk_outputs("R2");
        chk("R5 rst_o[4]", 64'(rst_o[4]), 64'd1);
    endtask

    task automatic t_upper;
        wr(12'h054, 32'h8000_0001, 1'b1); m_rst[63:32] &= ~32'h8000_0001;
        chk_outputs("R4");
        chk("R4 lines 63/32", {62'd0, rst_o[63], rst_o[32]}, 64'd0);
        wr(12'h094, 32'h0000_0002, 1'b1); m_stop[63:32] &= ~32'h0000_0002;
        chk("R4 clk_en_o[33]", 64'(clk_en_o[33]), 64'd1);
        chk_outputs("R4");
    endtask

    task automatic t_polarity;
        wr(12'h084, 32'hFFFF_FFFF, 1'b1); m_stop[31:0] = '0;
        chk("R6 all low stop", {32'd0, clk_en_o[31:0]}, 64'hFFFF_BFFF);
        wr(12'h080, 32'h0000_4008, 1'b1); m_stop[31:0] = 32'h0000_4008;
        chk("R6 line14", 64'(clk_en_o[14]), 64'd1);
        chk("R6 line3", 64'(clk_en_o[3]), 64'd0);
        chk_outputs("R6");
    endtask

    task automatic t_alias_read;
        logic [31:0] d;
        rd(12'h044, d); chk("R7 rd 044", 64'(d), 64'(m_rst[31:0]));
        rd(12'h084, d); chk("R7 rd 084", 64'(d), 64'(m_stop[31:0]));
        rd(12'h054, d); chk("R7 rd 054", 64'(d), 64'(m_rst[63:32]));
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        wr(12'h048, 32'hFFFF_FFFF, 1'b1);
        wr(12'h060, 32'hFFFF_FFFF, 1'b1);
        wr(12'h08C, 32'hFFFF_FFFF, 1'b1);
        wr(12'h044, 32'hFFFF_FFFF, 1'b0);
        chk_outputs("R9");
        rd(12'h048, d); chk("R9 rd 048", 64'(d), 64'd0);
        rd(12'h0A0, d); chk("R9 rd 0A0", 64'(d), 64'd0);
    endtask

    task automatic t_timing;
        logic [63:0] old_rst;
        old_rst = rst_o;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h044; bus_wdata = 32'h0000_0001;
        #1 chk("R8 before edge", rst_o, old_rst);
        @(posedge clk); #1;
        m_rst[0] = 1'b0;
        chk("R8 after edge", rst_o, m_rst);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        report();
    end

    initial begin
        m_rst  = '1;
        m_stop = {32'hFFFF_FFFF, 32'hFFFF_BFFF};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_set_clear_reset();
        t_upper();
        t_polarity();
        t_alias_read();
        t_unmapped();
        t_timing();
        report();
    end

endmodule